// File: doc/BRIEF.md
# Handshake stream tag filter

This stage sits on a point-to-point stream between a producer and a consumer. Data travels forward as a valid bit, a presence tag and a payload. An acknowledge travels back. Each item offered by the producer is either tagged present or tagged absent. An absent item is taken and thrown away. A present item goes to the consumer with its tag stripped, and it is released upstream only when the consumer takes it.

The stage holds no storage and no state. Its outputs are combinational functions of its inputs, so a present item reaches the consumer in the cycle it is offered. A reset guard holds both the forward valid and the upstream acknowledge low while the stage's active-high reset is high. As a result, a producer in a different reset domain never sees an item consumed by a stage that is still in reset.

Top module: `stream_tag_filter`

## Requirements
- R1: When `up_valid` is 0 and reset is low, `dn_valid` and `up_ack` are both 0 in that cycle.
- R2: When `up_valid` is 1 and `up_tag` is 0 (absent), with reset low, `up_ack` is 1 and `dn_valid` is 0 in the same cycle, so the item is consumed without being forwarded.
- R3: When `up_valid` is 1 and `up_tag` is 1 (present), with reset low, `dn_valid` is 1, `dn_data` equals `up_data`, and `up_ack` equals `dn_ack` in the same cycle.
- R4: `up_ack` is 0 in every cycle in which `rst` is 1, whatever the other inputs are.
- R5: `dn_valid` is 0 in every cycle in which `rst` is 1.
- R6: `dn_valid` and `dn_data` do not depend combinationally on `dn_ack`. Changing `dn_ack` within a cycle leaves them unchanged.
- R7: If `dn_valid` is 1 and `dn_ack` is 0 at a clock edge, then in the next cycle `dn_valid` is still 1 and `dn_data` is unchanged, provided the producer holds its item.
- R8: The sequence of payloads accepted downstream (`dn_valid` and `dn_ack` both 1) equals, in order and without duplication, the payloads of the present-tagged items accepted upstream.
- R9: The payload width is the parameter `DATA_W`, default 8. The tag is one extra bit, where 1 means present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; samples the synchronous reset and the checks |
| rst | input | 1 | Active-high synchronous reset |
| up_valid | input | 1 | Producer offers an item |
| up_tag | input | 1 | Presence tag of the offered item (1 = present) |
| up_data | input | DATA_W | Payload of the offered item |
| up_ack | output | 1 | Item consumed this cycle |
| dn_valid | output | 1 | Stage offers a payload downstream |
| dn_data | output | DATA_W | Payload offered downstream |
| dn_ack | input | 1 | Consumer takes the offered payload |

## Verification
Two things can happen in the same cycle and must be told apart. One is the reset guard suppressing the acknowledge. The other is the pass-through of a consumer acknowledge for a present item. The bench provokes this by raising reset while the producer holds a present item and the consumer acknowledges. In those cycles it expects no acknowledge and no valid output, and after reset drops the same item must still arrive exactly once. In the other cycles, absent-item drops and present-item stalls under random consumer backpressure alternate freely. Each cycle is judged against a behavioural model, and the accepted output stream is compared with a software filter of the input list.

// File: rtl/tf_pkg.sv
`timescale 1ns/1ps
package tf_pkg;
  typedef enum logic [1:0] {
    KIND_IDLE  = 2'd0,
    KIND_DROP  = 2'd1,
    KIND_PASS  = 2'd2
  } item_kind_e;

  // Classify the offered item from its valid and presence bits.
  function automatic item_kind_e classify(input logic vld, input logic present);
    if (!vld)         return KIND_IDLE;
    else if (!present) return KIND_DROP;
    else               return KIND_PASS;
  endfunction

  // Upstream release before the reset guard is applied.
  function automatic logic release_raw(input item_kind_e kind, input logic down_take);
    return (kind == KIND_DROP) || ((kind == KIND_PASS) && down_take);
  endfunction
endpackage

// File: rtl/tf_classifier.sv
`timescale 1ns/1ps
module tf_classifier
  import tf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              vld_i,
  input  logic              tag_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output item_kind_e        kind_o,
  output logic              fwd_vld_o,
  output logic [DATA_W-1:0] fwd_data_o,
  output logic              rel_o
);
  always_comb begin
    kind_o     = classify(vld_i, tag_i);
    fwd_vld_o  = (kind_o == KIND_PASS);
    fwd_data_o = data_i;
    rel_o      = release_raw(kind_o, take_i);
  end
endmodule

// File: rtl/tf_reset_guard.sv
`timescale 1ns/1ps
module tf_reset_guard #(
  parameter int N_SIG = 2
) (
  input  logic             hold_i,
  input  logic [N_SIG-1:0] raw_i,
  output logic [N_SIG-1:0] safe_o
);
  for (genvar g = 0; g < N_SIG; g++) begin : g_gate
    assign safe_o[g] = raw_i[g] & ~hold_i;
  end
endmodule

// File: rtl/stream_tag_filter.sv
`timescale 1ns/1ps
module stream_tag_filter
  import tf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic              up_tag,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_ack,
  output logic              dn_valid,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_ack
);
  localparam int GUARDED = 2;

  item_kind_e         kind;
  logic               fwd_vld_raw;
  logic               rel_raw;
  logic [GUARDED-1:0] guard_in;
  logic [GUARDED-1:0] guard_out;

  tf_classifier #(.DATA_W(DATA_W)) u_cls (
    .vld_i      (up_valid),
    .tag_i      (up_tag),
    .data_i     (up_data),
    .take_i     (dn_ack),
    .kind_o     (kind),
    .fwd_vld_o  (fwd_vld_raw),
    .fwd_data_o (dn_data),
    .rel_o      (rel_raw)
  );

  assign guard_in = {rel_raw, fwd_vld_raw};

  tf_reset_guard #(.N_SIG(GUARDED)) u_grd (
    .hold_i (rst),
    .raw_i  (guard_in),
    .safe_o (guard_out)
  );

  assign dn_valid = guard_out[0];
  assign up_ack   = guard_out[1];

  // Named events for the checks below.
  logic drop_evt, pass_evt, stall_evt;
  assign drop_evt  = up_ack && !dn_valid;
  assign pass_evt  = dn_valid && dn_ack;
  assign stall_evt = dn_valid && !dn_ack;

  // R4 R5
  always_comb begin
    if (rst === 1'b1) begin
      reset_quiet_chk: assert (!up_ack && !dn_valid);
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !up_valid |-> (!up_ack && !dn_valid));

  // R2
  absent_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_tag) |-> (drop_evt && !pass_evt));

  // R3
  present_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_tag) |-> (dn_valid && (dn_data == up_data) && (up_ack == dn_ack)));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_evt && $stable(up_data)) |=> (rst || (dn_valid && $stable(dn_data))));
endmodule

// File: tb/sim_stream_tag_filter.sv
`timescale 1ns/1ps
module sim_stream_tag_filter;
  localparam int W     = 8;
  localparam int N     = 300;
  localparam int LIMIT = 20000;

  logic         clk = 1'b0;
  logic         rst;
  logic         up_valid, up_tag, dn_ack;
  logic [W-1:0] up_data;
  logic         up_ack, dn_valid;
  logic [W-1:0] dn_data;

  always #2 clk = ~clk;

  stream_tag_filter #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_tag(up_tag), .up_data(up_data), .up_ack(up_ack),
    .dn_valid(dn_valid), .dn_data(dn_data), .dn_ack(dn_ack)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  logic         tags  [N];
  logic [W-1:0] datas [N];
  logic [W-1:0] filt  [N];
  int           nfilt;

  initial begin
    int idx = 0, optr = 0, cyc = 0;
    bit presenting = 0;
    bit prev_stall = 0;
    logic [W-1:0] prev_data = '0;
    logic sv_v;
    logic [W-1:0] sv_d;

    nfilt = 0;
    for (int i = 0; i < N; i++) begin
      tags[i]  = ($urandom_range(0, 2) != 0);
      datas[i] = W'($urandom);
      if (tags[i]) begin
        filt[nfilt] = datas[i];
        nfilt++;
      end
    end

    // Reset phase: a present item and an acknowledging consumer.
    rst = 1'b1; up_valid = 1'b1; up_tag = 1'b1; up_data = 8'hA5; dn_ack = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk(up_ack == 1'b0, "R4", up_ack, 0);
      chk(dn_valid == 1'b0, "R5", dn_valid, 0);
    end

    while (idx < N && cyc < LIMIT) begin
      @(posedge clk); #1;
      cyc++;
      rst = (cyc >= 150 && cyc < 153);
      if (!presenting && $urandom_range(0, 9) < 7) presenting = 1;
      up_valid = presenting;
      up_tag   = tags[idx];
      up_data  = presenting ? datas[idx] : W'($urandom);
      if (rst) up_tag = 1'b1;
      dn_ack   = ($urandom_range(0, 9) < 6) || rst;
      #1;
      if (rst) begin
        chk(up_ack == 1'b0, "R4", up_ack, 1'b0);
        chk(dn_valid == 1'b0, "R5", dn_valid, 1'b0);
        prev_stall = 0;
        if (presenting) up_tag = tags[idx];
        continue;
      end
      if (!up_valid) begin
        chk(!dn_valid && !up_ack, "R1", {dn_valid, up_ack}, 0);
      end else if (!up_tag) begin
        chk(up_ack && !dn_valid, "R2", {up_ack, dn_valid}, 2);
      end else begin
        chk(dn_valid == 1'b1, "R3", dn_valid, 1);
        chk(dn_data == up_data, "R3", dn_data, up_data);
        chk(up_ack == dn_ack, "R3", up_ack, dn_ack);
      end
      if (prev_stall) begin
        chk(dn_valid && dn_data == prev_data, "R7", dn_data, prev_data);
      end
      // R6: flip the consumer acknowledge within the cycle.
      sv_v = dn_valid; sv_d = dn_data;
      dn_ack = ~dn_ack; #0.5;
      chk(dn_valid == sv_v && dn_data == sv_d, "R6", dn_valid, sv_v);
      dn_ack = ~dn_ack; #0.5;
      // Transfers at the coming edge.
      if (dn_valid && dn_ack) begin
        if (optr < nfilt) chk(dn_data == filt[optr], "R8", dn_data, filt[optr]);
        else              chk(1'b0, "R8", optr, nfilt);
        optr++;
      end
      prev_stall = dn_valid && !dn_ack;
      prev_data  = dn_data;
      if (up_valid && up_ack) begin
        idx++;
        presenting = 0;
      end
    end

    if (cyc >= LIMIT) chk(1'b0, "watchdog", cyc, LIMIT);
    // R8 R9: every present item of the 8-bit stream delivered exactly once.
    chk(optr == nfilt, "R8", optr, nfilt);
    chk($bits(dn_data) == 8, "R9", $bits(dn_data), 8);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule